// File: doc/BRIEF.md
# Vector Double-to-Unsigned Truncating Converter

This block takes a vector of IEEE-754 double-precision values and turns each lane into an unsigned 64-bit integer. It always truncates toward zero and does not look at any rounding-mode setting held elsewhere in the chip. Each lane is split into one of these cases: NaN, zero, a negative value with a fraction, a negative value of one or more, in range, or above range. Each case gives a fixed result and a fixed set of flags. An input that is invalid or out of range returns zero. It is never saturated to the largest value.

A caller presents a full source vector together with a valid strobe and an invalid-operation enable bit. One clock later the block registers the result vector and the operation flags and raises an output-valid strobe. The flags are ORed across the lanes. When the enable bit is set, a trap request goes with any inexact result. The registered outputs keep their values until the next valid input.

Top module: `vcvt_dp2u64_rz`

## Requirements
- R1: `out_vld` is high in the cycle after each cycle in which `in_vld` is high, and low otherwise. The result, flags and trap load only on valid inputs and hold their values between them.
- R2: Lane k of the result, bits [64k+63:64k], is the truncated value of the double in the matching bits of `src`. Each lane is converted independently of the others.
- R3: A lane holding +0, -0 or a positive exact integer below 2^64 returns that value and sets no flag.
- R4: A positive in-range lane with a nonzero discarded fraction returns its truncated value and sets `flag_inx`. Positive subnormals and positive values below 1 are in this case and return 0.
- R5: A lane strictly between -1 and 0 (exponent field below 1023, sign bit 1, not zero) returns 0 and sets `flag_inx`.
- R6: A lane of -1 or below, including -infinity, returns 0 and sets `flag_cvi`.
- R7: A lane of 2^64 or above, including +infinity, returns 0 and sets `flag_cvi`.
- R8: A NaN lane (exponent field all ones, fraction nonzero) returns 0 and sets `flag_cvi`. It also sets `flag_snan` when fraction bit 51 is 0 (signalling).
- R9: `trap` equals `flag_inx` ANDed with the `inv_en` value sampled with the data. Invalid cases never raise it on their own.
- R10: Each output flag is the OR of that flag over all lanes.
- R11: After reset, `out_vld`, `res`, all flags and `trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Source vector valid |
| inv_en | input | 1 | Invalid-operation enable; requests a trap on inexact results |
| src | input | 64*LANES | Packed double-precision lanes, lane 0 in the low bits |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| res | output | 64*LANES | Packed unsigned 64-bit results |
| flag_snan | output | 1 | Signalling-NaN invalid flag |
| flag_cvi | output | 1 | Conversion-invalid flag |
| flag_inx | output | 1 | Inexact flag |
| trap | output | 1 | Trap request |

## Verification
The bench builds the block with its default LANES=2. Two lanes are enough to pair a clean lane with a flagged one, which shows both the per-lane independence and the OR-merging of the flags. The reference model computes each expected value with real arithmetic, subtracting powers of two greedily. It does not reuse the bit-level shifting of the design. This makes it possible to cover every shift amount, the edges at -1, 2^63 and 2^64, subtlety such as subnormals and negative zero, and random bit patterns across the whole exponent range.

// File: rtl/vcvt_dp2u64_rz.sv
module vcvt_dp2u64_rz #(
  parameter int LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              inv_en,
  input  logic [64*LANES-1:0] src,
  output logic              out_vld,
  output logic [64*LANES-1:0] res,
  output logic              flag_snan,
  output logic              flag_cvi,
  output logic              flag_inx,
  output logic              trap
);
  localparam int W = 64 * LANES;
  localparam logic [10:0] BIAS = 11'd1023;
  localparam logic [10:0] TOP  = 11'd1087;

  function automatic logic [66:0] cvt(input logic [63:0] x);
    logic [10:0] e;
    logic [51:0] f;
    logic [63:0] m, r;
    logic sn, cv, ix;
    int sh;
    e = x[62:52];
    f = x[51:0];
    m = {11'd0, 1'b1, f};
    r = '0; sn = 1'b0; cv = 1'b0; ix = 1'b0;
    sh = 0;
    if (e == 11'h7FF && f != '0) begin
      cv = 1'b1;
      sn = ~f[51];
    end else if (e == '0 && f == '0) begin
      r = '0;
    end else if (x[63]) begin
      if (e >= BIAS) cv = 1'b1;
      else ix = 1'b1;
    end else if (e >= TOP) begin
      cv = 1'b1;
    end else if (e < BIAS) begin
      ix = 1'b1;
    end else begin
      sh = int'(e) - 1023;
      if (sh >= 52) r = m << (sh - 52);
      else begin
        r  = m >> (52 - sh);
        ix = |(m & ((64'd1 << (52 - sh)) - 64'd1));
      end
    end
    return {sn, cv, ix, r};
  endfunction

  logic [W-1:0] res_d;
  logic sn_d, cv_d, ix_d;

  always_comb begin
    logic [66:0] o;
    res_d = '0; sn_d = 1'b0; cv_d = 1'b0; ix_d = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      o = cvt(src[64*k +: 64]);
      res_d[64*k +: 64] = o[63:0];
      sn_d |= o[66];
      cv_d |= o[65];
      ix_d |= o[64];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      res <= '0;
      flag_snan <= 1'b0;
      flag_cvi <= 1'b0;
      flag_inx <= 1'b0;
      trap <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res <= res_d;
        flag_snan <= sn_d;
        flag_cvi <= cv_d;
        flag_inx <= ix_d;
        trap <= ix_d & inv_en;
      end
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld);
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> $stable(res) && $stable(flag_cvi) && $stable(trap));
  // R8
  snan_cvi_chk: assert property (@(posedge clk) disable iff (!rst_n) flag_snan |-> flag_cvi);
  // R9
  trap_inx_chk: assert property (@(posedge clk) disable iff (!rst_n) trap |-> flag_inx);
  // R9
  trap_en_chk: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && !inv_en) |=> !trap);
endmodule

// File: tb/tb_vcvt_dp2u64_rz.sv
module tb_vcvt_dp2u64_rz;
  logic clk = 0, rst_n = 0, in_vld = 0, inv_en = 0;
  logic [127:0] src = '0;
  logic out_vld, flag_snan, flag_cvi, flag_inx, trap;
  logic [127:0] res;
  int checks = 0, failures = 0;
  logic [127:0] e_res = '0;
  logic e_sn = 0, e_cv = 0, e_ix = 0, e_tr = 0;

  always #5 clk = ~clk;

  vcvt_dp2u64_rz #(.LANES(2)) dut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .inv_en(inv_en),
    .src(src), .out_vld(out_vld), .res(res), .flag_snan(flag_snan), .flag_cvi(flag_cvi),
    .flag_inx(flag_inx), .trap(trap));

  task automatic model(input logic [63:0] x, output logic [63:0] r, output logic sn, cv, ix);
    real d;
    r = '0; sn = 0; cv = 0; ix = 0;
    d = $bitstoreal(x);
    if (x[62:52] == 11'h7FF && x[51:0] != 0) begin cv = 1; sn = !x[51]; end
    else if (d <= -1.0) cv = 1;
    else if (d < 0.0) ix = 1;
    else if (d >= 2.0 ** 64) cv = 1;
    else begin
      for (int b = 63; b >= 0; b--)
        if (d >= 2.0 ** b) begin r[b] = 1'b1; d = d - 2.0 ** b; end
      ix = (d > 0.0);
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] a, input logic [127:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic step(input logic [127:0] v, input logic vl, input logic en, input string tag);
    logic [63:0] r0, r1;
    logic s0, c0, i0, s1, c1, i1;
    src = v; in_vld = vl; inv_en = en;
    if (vl) begin
      model(v[63:0], r0, s0, c0, i0);
      model(v[127:64], r1, s1, c1, i1);
      e_res = {r1, r0};
      e_sn = s0 | s1; e_cv = c0 | c1; e_ix = i0 | i1;
      e_tr = (i0 | i1) & en;
    end
    @(negedge clk);
    chk({tag, " R1 vld"}, {127'd0, out_vld}, {127'd0, vl});
    chk({tag, " R2 res"}, res, e_res);
    chk({tag, " R10 flags"}, {125'd0, flag_snan, flag_cvi, flag_inx}, {125'd0, e_sn, e_cv, e_ix});
    chk({tag, " R9 trap"}, {127'd0, trap}, {127'd0, e_tr});
  endtask

  function automatic logic [63:0] dbl(input real r);
    return $realtobits(r);
  endfunction

  function automatic logic [63:0] rnd64();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if ($urandom_range(0, 3) != 0) v[62:52] = 11'(1010 + $urandom_range(0, 85));
    return v;
  endfunction

  initial begin
    fork
      begin repeat (100000) @(posedge clk);
        failures++; $display("FAIL watchdog expired"); end
    join_none
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset", {res, out_vld, flag_snan, flag_cvi, flag_inx, trap}, '0);
    rst_n = 1;
    @(negedge clk);
    // R3 zeros and exact integers
    step({64'h8000_0000_0000_0000, 64'h0}, 1, 1, "R3 zeros");
    step({dbl(12345.0), dbl(1.0)}, 1, 1, "R3 ints");
    step({64'h43EF_FFFF_FFFF_FFFF, dbl(2.0 ** 63)}, 1, 1, "R3 top");
    // R4 fractions
    step({dbl(7.75), dbl(0.5)}, 1, 0, "R4 frac");
    step({64'h0000_0000_0000_0001, dbl(4503599627370495.5)}, 1, 0, "R4 subnorm");
    // R5 negative fraction, trap with enable (R9)
    step({dbl(0.0), dbl(-0.25)}, 1, 0, "R5 noen");
    step({dbl(0.0), dbl(-0.999)}, 1, 1, "R5 en");
    // R6
    step({dbl(-1.0), dbl(-1.0e300)}, 1, 1, "R6 neg");
    step({64'hFFF0_0000_0000_0000, dbl(3.0)}, 1, 1, "R6 ninf");
    // R7
    step({dbl(2.0 ** 64), 64'h7FF0_0000_0000_0000}, 1, 1, "R7 big");
    // R8 NaNs
    step({64'h7FF8_0000_0000_0000, dbl(5.0)}, 1, 1, "R8 qnan");
    step({dbl(5.0), 64'h7FF0_0000_0000_0001}, 1, 1, "R8 snan");
    // R10 mixed lanes
    step({dbl(9.5), 64'hFFF4_0000_0000_0000}, 1, 1, "R10 mix");
    // R1 hold with garbage input and no valid
    step({64'h7FF0_0000_0000_0001, dbl(3.5)}, 0, 1, "R1 hold");
    step('0, 0, 0, "R1 hold2");
    // R2 every shift amount
    for (int s = 0; s < 64; s++)
      step({dbl(2.0 ** s + 0.5), dbl(2.0 ** s)}, 1, s[0], "R2 shift");
    for (int n = 0; n < 1500; n++)
      step({rnd64(), rnd64()}, ($urandom_range(0, 4) != 0), $urandom_range(0, 1), "R2 rand");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule